// File: doc/BRIEF.md
# Sector Protection Mode Controller with Password Unlock

This block decides whether the per-sector protection bits of a parallel NOR memory model may be changed. It holds three pieces of state. A one-time-programmable lock register selects between two schemes and carries a secure-region lock bit. A password store holds several 16-bit words. A volatile unlock flag, `ppb_lock`, shows whether the protection bits are currently open to change (1) or guarded (0).

In the default (persistent) scheme the flag comes up open after every reset, and software can close it with a single command. Once closed, no command opens it again until the next reset. In the password scheme the flag comes up closed. It opens only when the full password is presented word by word, in any order, followed by an execute command. A failed attempt leaves the flag closed, raises three failure flags and keeps `busy` asserted until a hardware reset. After the password scheme has been chosen, the password can no longer be read or reprogrammed.

Two resets are provided. `por_n` models power-on: it returns the lock register and password store to their erased state and also clears all volatile state. `rst_n` is the hardware reset: it clears only volatile state, so the programmed lock bits and password survive it.

Top module: `prot_lock_ctrl`

## Requirements
- R1: After `por_n`, a lock-register read (op 2) returns 0xFFFF, a password read (op 4) returns 0xFFFF, `ppb_lock` is 1, `busy` and all three failure flags are 0, and a status read (op 9) returns 0x0080.
- R2: A lock-register program (op 1) keeps `busy` high for LR_CYC cycles and then clears the lock bits whose data bit is 0. Only bit 0 (secure-region lock), bit 1 (persistent scheme) and bit 2 (password scheme) can be programmed; bits 15..3 stay 1 whatever is written. Bit 0 can be programmed independently, before or after a scheme bit.
- R3: A lock-register program with data bits 1 and 2 both 0 aborts: `busy` does not rise and the register is unchanged.
- R4: Lock bits never return to 1, except on `por_n`, and they survive `rst_n`. Once either scheme bit is 0, a request to clear the other scheme bit is masked off.
- R5: While bit 2 of the lock register is 1, `rst_n` leaves `ppb_lock` at 1. The clear command (op 8) drives it to 0, and no command sets it back to 1 before a reset.
- R6: While bit 2 is 0, `ppb_lock` is 0 after `rst_n` and right after the password scheme has been chosen. Only a successful unlock sets it to 1; op 8 returns it to 0.
- R7: A password program (op 3) ANDs `wdata` into the word at `addr`, so bits only go from 1 to 0. A password read returns the stored word.
- R8: Once bit 2 is 0, password reads return 0xFFFF and password programs leave the stored words unchanged.
- R9: Unlock works only in the password scheme. Op 5 starts an attempt, op 6 presents the word `wdata` for index `addr` (any order, and the last entry for an index counts), and op 7 executes it. Execution keeps `busy` high for UNL_CYC cycles; then, if all four words were presented and all match, `ppb_lock` becomes 1.
- R10: An unlock executed with a missing or mismatching word leaves `ppb_lock` unchanged, sets `flag_prog_fail`, `flag_prog_err` and `flag_abort` to 1, and holds `busy` at 1 until `rst_n` or `por_n`.
- R11: A status read while busy returns bit 7 as the complement of bit 7 of the last data word that started or fed the operation, and bit 6 toggling from 0 on each read (first read 1); all other bits are 0. A status read when idle returns 0x0080.
- R12: While `busy` is 1, every command other than a status read is ignored, and `rdata` keeps its value.
- R13: Op 5 clears the record of received password words, so words presented before it do not count toward the unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; erases non-volatile state |
| rst_n | input | 1 | Hardware reset, active low; clears volatile state only |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Command code (0 none, 1..9 as in the requirements) |
| addr | input | 2 | Password word index |
| wdata | input | 16 | Command data |
| ppb_lock | output | 1 | 1 = protection bits may be changed |
| busy | output | 1 | Timed operation running or failed unlock holding |
| rdata | output | 16 | Registered read data, updated one cycle after a read |
| flag_prog_fail | output | 1 | Program-status failure flag |
| flag_prog_err | output | 1 | Status-register program-error flag |
| flag_abort | output | 1 | Write-buffer abort flag |

## Verification
The bench builds the block with LR_CYC = 6 and UNL_CYC = 5 instead of the longer defaults. The six-cycle lock-program window leaves room for three status reads and an ignored password program inside one operation. The short unlock time keeps the stuck-busy failure and its recovery through a hardware reset inside a short run. The four-word default password lets out-of-order entry, a missing word and a mismatching word be tried separately.

// File: rtl/prot_lock_pkg.sv
package prot_lock_pkg;

   // command codes carried on cmd_op
   typedef enum logic [3:0] {
      OP_NOP       = 4'd0,
      OP_LR_PROG   = 4'd1,
      OP_LR_READ   = 4'd2,
      OP_PW_PROG   = 4'd3,
      OP_PW_READ   = 4'd4,
      OP_UNL_START = 4'd5,
      OP_UNL_WORD  = 4'd6,
      OP_UNL_EXEC  = 4'd7,
      OP_PPB_CLR   = 4'd8,
      OP_STAT_READ = 4'd9
   } op_e;

   // lock register field positions (programmed = 0)
   localparam int LR_SECURE  = 0;
   localparam int LR_PERSIST = 1;
   localparam int LR_PASSWD  = 2;
   localparam int LR_FIELDS  = 3;

   // status word bit positions
   localparam int ST_POLL = 7;
   localparam int ST_TOG  = 6;

   // which timed operation owns the busy timer
   typedef enum logic {JOB_LR = 1'b0, JOB_UNL = 1'b1} job_e;

endpackage

// File: rtl/prot_busy_timer.sv
module prot_busy_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] load,
   output logic             active,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= load;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign active = (cnt_q != '0);
   assign done   = (cnt_q == CNT_W'(1));

   // R2: a running count falls by one every cycle
   p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/prot_lock_reg.sv
module prot_lock_reg
   import prot_lock_pkg::*;
#(
   parameter int LR_W = 16
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            cap,
   input  logic [LR_W-1:0] cap_data,
   input  logic            commit,
   output logic [LR_W-1:0] lr,
   output logic [LR_W-1:0] lr_next,
   output logic            both_modes
);

   localparam logic [LR_W-1:0] FIELD_MASK = {{(LR_W-LR_FIELDS){1'b0}}, {LR_FIELDS{1'b1}}};

   logic [LR_W-1:0] lr_q;
   logic [LR_W-1:0] pend_q;
   logic [LR_W-1:0] eff;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         pend_q <= '1;
      else if (cap)
         pend_q <= cap_data;
   end

   always_comb begin
      eff = pend_q | ~FIELD_MASK;
      if (!lr_q[LR_PERSIST]) eff[LR_PASSWD]  = 1'b1;
      if (!lr_q[LR_PASSWD])  eff[LR_PERSIST] = 1'b1;
      lr_next = lr_q & eff;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         lr_q <= '1;
      else if (commit)
         lr_q <= lr_next;
   end

   assign lr         = lr_q;
   assign both_modes = !cap_data[LR_PERSIST] && !cap_data[LR_PASSWD];

   // R4: no lock bit ever goes back to 1
   p_bits_never_rise_r4: assert property (@(posedge clk) disable iff (!por_n)
      1'b1 |=> ((lr_q & ~$past(lr_q)) == '0));

   // R4: the two scheme bits are never both programmed
   p_modes_exclusive_r4: assert property (@(posedge clk) disable iff (!por_n)
      !(!lr_q[LR_PERSIST] && !lr_q[LR_PASSWD]));

   // R2: reserved bits stay at 1
   p_reserved_ones_r2: assert property (@(posedge clk) disable iff (!por_n)
      ((lr_q | FIELD_MASK) == '1));

endmodule

// File: rtl/prot_pwd_store.sv
module prot_pwd_store #(
   parameter int DW       = 16,
   parameter int PW_WORDS = 4,
   parameter int AW       = 2
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          rst_n,
   input  logic          pw_mode,
   input  logic          prog_en,
   input  logic          unl_start,
   input  logic          unl_word,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rd_word,
   output logic          match_ok
);

   localparam int FLAT_W = PW_WORDS * DW;

   logic [FLAT_W-1:0]   flat;
   logic [PW_WORDS-1:0] seen;
   logic [PW_WORDS-1:0] miss;

   for (genvar i = 0; i < PW_WORDS; i++) begin : g_word
      logic [DW-1:0] w_q;
      logic          seen_q;
      logic          miss_q;
      logic          hit;

      assign hit = (addr == AW'(i));

      // non-volatile word: erased only at power-on
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            w_q <= '1;
         else if (prog_en && hit && !pw_mode)
            w_q <= w_q & wdata;
      end

      // volatile record of the word entered in this attempt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seen_q <= 1'b0;
            miss_q <= 1'b0;
         end else if (unl_start) begin
            seen_q <= 1'b0;
            miss_q <= 1'b0;
         end else if (unl_word && hit) begin
            seen_q <= 1'b1;
            miss_q <= (wdata != w_q);
         end
      end

      assign flat[i*DW +: DW] = w_q;
      assign seen[i]          = seen_q;
      assign miss[i]          = miss_q;
   end

   assign rd_word  = pw_mode ? '1 : flat[addr*DW +: DW];
   assign match_ok = (&seen) && !(|miss);

   // R7: stored password bits only fall
   p_store_only_clears_r7: assert property (@(posedge clk) disable iff (!por_n)
      1'b1 |=> ((flat & ~$past(flat)) == '0));

   // R8: once the password scheme is chosen the store is frozen
   p_frozen_in_pw_mode_r8: assert property (@(posedge clk) disable iff (!por_n)
      pw_mode |=> $stable(flat));

endmodule

// File: rtl/prot_lock_ctrl.sv
module prot_lock_ctrl
   import prot_lock_pkg::*;
#(
   parameter int DW       = 16,
   parameter int PW_WORDS = 4,
   parameter int LR_CYC   = 8,
   parameter int UNL_CYC  = 12
) (
   input  logic                        clk,
   input  logic                        por_n,
   input  logic                        rst_n,
   input  logic                        cmd_valid,
   input  logic [3:0]                  cmd_op,
   input  logic [$clog2(PW_WORDS)-1:0] addr,
   input  logic [DW-1:0]               wdata,
   output logic                        ppb_lock,
   output logic                        busy,
   output logic [DW-1:0]               rdata,
   output logic                        flag_prog_fail,
   output logic                        flag_prog_err,
   output logic                        flag_abort
);

   localparam int AW    = $clog2(PW_WORDS);
   localparam int MAXC  = (LR_CYC > UNL_CYC) ? LR_CYC : UNL_CYC;
   localparam int CNT_W = $clog2(MAXC + 1);

   // elaboration checks
   if (DW < 8) begin : g_bad_dw
      $error("prot_lock_ctrl: DW must be at least 8");
   end
   if (PW_WORDS < 2 || (1 << AW) != PW_WORDS) begin : g_bad_words
      $error("prot_lock_ctrl: PW_WORDS must be a power of two, at least 2");
   end
   if (LR_CYC < 1 || UNL_CYC < 1) begin : g_bad_cyc
      $error("prot_lock_ctrl: cycle counts must be at least 1");
   end

   logic          rst_all;
   logic          accept;
   logic          lr_start, unl_exec, stat_rd;
   logic          tmr_start, tmr_active, tmr_done;
   logic [CNT_W-1:0] tmr_load;
   logic [DW-1:0] lr, lr_next;
   logic          both_modes, pw_mode, match_ok;
   logic [DW-1:0] pw_word;
   logic          lr_commit, unl_done;
   job_e          job_q;
   logic          flip_q, fail_q, tog_q, d7_q;
   logic [DW-1:0] rdata_q;

   assign rst_all = rst_n & por_n;
   assign busy    = tmr_active | fail_q;
   assign accept  = cmd_valid && !busy;
   assign stat_rd = cmd_valid && (cmd_op == OP_STAT_READ);
   assign pw_mode = !lr[LR_PASSWD];

   assign lr_start  = accept && (cmd_op == OP_LR_PROG) && !both_modes;
   assign unl_exec  = accept && (cmd_op == OP_UNL_EXEC) && pw_mode;
   assign tmr_start = lr_start | unl_exec;
   assign tmr_load  = lr_start ? CNT_W'(LR_CYC) : CNT_W'(UNL_CYC);
   assign lr_commit = tmr_done && (job_q == JOB_LR);
   assign unl_done  = tmr_done && (job_q == JOB_UNL);

   prot_busy_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_all),
      .start  (tmr_start),
      .load   (tmr_load),
      .active (tmr_active),
      .done   (tmr_done)
   );

   prot_lock_reg #(.LR_W(DW)) u_lockreg (
      .clk        (clk),
      .por_n      (por_n),
      .cap        (lr_start),
      .cap_data   (wdata),
      .commit     (lr_commit),
      .lr         (lr),
      .lr_next    (lr_next),
      .both_modes (both_modes)
   );

   prot_pwd_store #(.DW(DW), .PW_WORDS(PW_WORDS), .AW(AW)) u_pwd (
      .clk       (clk),
      .por_n     (por_n),
      .rst_n     (rst_all),
      .pw_mode   (pw_mode),
      .prog_en   (accept && (cmd_op == OP_PW_PROG)),
      .unl_start (accept && (cmd_op == OP_UNL_START) && pw_mode),
      .unl_word  (accept && (cmd_op == OP_UNL_WORD) && pw_mode),
      .addr      (addr),
      .wdata     (wdata),
      .rd_word   (pw_word),
      .match_ok  (match_ok)
   );

   always_ff @(posedge clk or negedge rst_all) begin
      if (!rst_all)
         job_q <= JOB_LR;
      else if (lr_start)
         job_q <= JOB_LR;
      else if (unl_exec)
         job_q <= JOB_UNL;
   end

   // flip_q records a departure from the scheme's reset value of ppb_lock
   always_ff @(posedge clk or negedge rst_all) begin
      if (!rst_all)
         flip_q <= 1'b0;
      else if (unl_done && match_ok)
         flip_q <= 1'b1;
      else if (lr_commit && lr[LR_PASSWD] && !lr_next[LR_PASSWD])
         flip_q <= 1'b0;
      else if (accept && (cmd_op == OP_PPB_CLR))
         flip_q <= !pw_mode;
   end

   assign ppb_lock = pw_mode ? flip_q : !flip_q;

   always_ff @(posedge clk or negedge rst_all) begin
      if (!rst_all)
         fail_q <= 1'b0;
      else if (unl_done && !match_ok)
         fail_q <= 1'b1;
   end

   assign flag_prog_fail = fail_q;
   assign flag_prog_err  = fail_q;
   assign flag_abort     = fail_q;

   // polling state: toggle bit and the data bit 7 to complement
   always_ff @(posedge clk or negedge rst_all) begin
      if (!rst_all) begin
         tog_q <= 1'b0;
         d7_q  <= 1'b0;
      end else begin
         if (tmr_start)
            tog_q <= 1'b0;
         else if (stat_rd && busy)
            tog_q <= !tog_q;
         if (lr_start || (accept && (cmd_op == OP_UNL_WORD) && pw_mode))
            d7_q <= wdata[7];
      end
   end

   always_ff @(posedge clk or negedge rst_all) begin
      if (!rst_all)
         rdata_q <= '0;
      else if (stat_rd) begin
         rdata_q <= '0;
         if (busy) begin
            rdata_q[ST_POLL] <= !d7_q;
            rdata_q[ST_TOG]  <= !tog_q;
         end else
            rdata_q[ST_POLL] <= 1'b1;
      end else if (accept && (cmd_op == OP_LR_READ))
         rdata_q <= lr;
      else if (accept && (cmd_op == OP_PW_READ))
         rdata_q <= pw_word;
   end

   assign rdata = rdata_q;

   // R5: in the persistent scheme a closed lock stays closed until reset
   p_persist_no_reopen_r5: assert property (@(posedge clk) disable iff (!rst_all)
      (!pw_mode && !ppb_lock) |=> !ppb_lock);

   // R6: in the password scheme only a finishing unlock opens the lock
   p_pw_open_only_by_unlock_r6: assert property (@(posedge clk) disable iff (!rst_all)
      (pw_mode && !ppb_lock && !unl_done) |=> !ppb_lock);

   // R10: a failed unlock keeps busy and the flags until reset
   p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_all)
      fail_q |=> (fail_q && busy));

   // R12: read data holds while busy unless a status read arrives
   p_rdata_hold_busy_r12: assert property (@(posedge clk) disable iff (!rst_all)
      (busy && !stat_rd) |=> $stable(rdata_q));

endmodule

// File: tb/prot_lock_ctrl_test.sv
module prot_lock_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int LR_CYC     = 6;
   localparam int UNL_CYC    = 5;

   localparam logic [3:0] C_LR_PROG = 4'd1, C_LR_READ = 4'd2, C_PW_PROG = 4'd3,
                          C_PW_READ = 4'd4, C_UNL_START = 4'd5, C_UNL_WORD = 4'd6,
                          C_UNL_EXEC = 4'd7, C_PPB_CLR = 4'd8, C_STAT = 4'd9;

   logic        clk = 1'b0;
   logic        por_n, rst_n;
   logic        cmd_valid;
   logic [3:0]  cmd_op;
   logic [1:0]  addr;
   logic [15:0] wdata;
   logic        ppb_lock, busy, flag_prog_fail, flag_prog_err, flag_abort;
   logic [15:0] rdata;

   int checks = 0;
   int fails  = 0;
   logic rd_flag = 1'b0;
   logic take    = 1'b0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   prot_lock_ctrl #(.DW(16), .PW_WORDS(4), .LR_CYC(LR_CYC), .UNL_CYC(UNL_CYC)) uut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .addr(addr), .wdata(wdata), .ppb_lock(ppb_lock), .busy(busy), .rdata(rdata),
      .flag_prog_fail(flag_prog_fail), .flag_prog_err(flag_prog_err), .flag_abort(flag_abort)
   );

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compares read data one cycle after each read command
   always @(posedge clk) take <= rd_flag;
   always @(negedge clk) begin
      if (take) begin
         if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL scoreboard underflow actual=%h expected=none", rdata);
         end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rdata, e, t);
         end
      end
   end

   task automatic issue(input logic [3:0] op, input logic [1:0] a, input logic [15:0] d);
      cmd_valid = 1'b1; cmd_op = op; addr = a; wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 4'd0; addr = 2'd0; wdata = 16'h0;
   endtask

   task automatic rd(input logic [3:0] op, input logic [1:0] a, input logic [15:0] exp,
                     input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      rd_flag = 1'b1;
      issue(op, a, 16'h0);
      rd_flag = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 40 && busy; i++) @(negedge clk);
   endtask

   task automatic hw_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic unlock_all(input logic [15:0] w0, input logic [15:0] w1,
                             input logic [15:0] w2, input logic [15:0] w3);
      issue(C_UNL_START, 2'd0, 16'h0);
      issue(C_UNL_WORD, 2'd2, w2);
      issue(C_UNL_WORD, 2'd0, w0);
      issue(C_UNL_WORD, 2'd3, w3);
      issue(C_UNL_WORD, 2'd1, w1);
      issue(C_UNL_EXEC, 2'd0, 16'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      por_n = 1'b0; rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 4'd0; addr = 2'd0; wdata = 16'h0;
      repeat (3) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk({15'd0, ppb_lock}, 16'd1, "R1 ppb_lock after power-on");
      chk({15'd0, busy}, 16'd0, "R1 busy after power-on");
      chk({13'd0, flag_prog_fail, flag_prog_err, flag_abort}, 16'd0, "R1 flags after power-on");
      rd(C_LR_READ, 2'd0, 16'hFFFF, "R1 lock register erased");
      rd(C_PW_READ, 2'd1, 16'hFFFF, "R1 password erased");
      rd(C_STAT, 2'd0, 16'h0080, "R1 idle status");

      // R7 password program ANDs bits
      issue(C_PW_PROG, 2'd0, 16'h1234);
      issue(C_PW_PROG, 2'd1, 16'hABCD);
      issue(C_PW_PROG, 2'd2, 16'h0F0F);
      issue(C_PW_PROG, 2'd3, 16'h8001);
      issue(C_PW_PROG, 2'd0, 16'hFF00);
      rd(C_PW_READ, 2'd0, 16'h1200, "R7 word0 only clears bits");
      rd(C_PW_READ, 2'd3, 16'h8001, "R7 word3 readback");

      // R9 unlock ignored outside the password scheme
      unlock_all(16'h1200, 16'hABCD, 16'h0F0F, 16'h8001);
      chk({15'd0, busy}, 16'd0, "R9 unlock ignored in persistent scheme");

      // R5 persistent clear and reset
      issue(C_PPB_CLR, 2'd0, 16'h0);
      chk({15'd0, ppb_lock}, 16'd0, "R5 clear command closes lock");
      unlock_all(16'h1200, 16'hABCD, 16'h0F0F, 16'h8001);
      chk({15'd0, ppb_lock}, 16'd0, "R5 nothing reopens lock");
      hw_reset();
      chk({15'd0, ppb_lock}, 16'd1, "R5 reset reopens lock");

      // R3 both scheme bits at once aborts
      issue(C_LR_PROG, 2'd0, 16'hFFF9);
      chk({15'd0, busy}, 16'd0, "R3 abort raises no busy");
      rd(C_LR_READ, 2'd0, 16'hFFFF, "R3 register unchanged");

      // R2 R11 R12 choose password scheme, reserved bit 15 written 0
      issue(C_LR_PROG, 2'd0, 16'h7FFB);
      chk({15'd0, busy}, 16'd1, "R2 busy during lock program");
      rd(C_STAT, 2'd0, 16'h0040, "R11 first busy status read");
      rd(C_STAT, 2'd0, 16'h0000, "R11 second busy status read");
      rd(C_STAT, 2'd0, 16'h0040, "R11 third busy status read");
      issue(C_PW_PROG, 2'd3, 16'h0000);
      chk({15'd0, busy}, 16'd1, "R2 still busy after five cycles");
      wait_idle();
      rd(C_LR_READ, 2'd0, 16'hFFFB, "R2 password bit set, reserved kept");
      chk({15'd0, ppb_lock}, 16'd0, "R6 lock closes on choosing password scheme");

      // R4 other scheme masked, secure bit independent
      issue(C_LR_PROG, 2'd0, 16'hFFFD);
      wait_idle();
      rd(C_LR_READ, 2'd0, 16'hFFFB, "R4 persistent bit masked");
      issue(C_LR_PROG, 2'd0, 16'hFFFE);
      wait_idle();
      rd(C_LR_READ, 2'd0, 16'hFFFA, "R2 secure bit programmed after scheme");

      // R8 password hidden and frozen
      rd(C_PW_READ, 2'd0, 16'hFFFF, "R8 password reads as ones");
      issue(C_PW_PROG, 2'd1, 16'h0000);

      // R9 successful unlock, out of order (also proves R8 and R12 writes were dropped)
      unlock_all(16'h1200, 16'hABCD, 16'h0F0F, 16'h8001);
      chk({15'd0, busy}, 16'd1, "R9 busy during unlock");
      chk({15'd0, ppb_lock}, 16'd0, "R9 lock closed before unlock completes");
      wait_idle();
      chk({15'd0, ppb_lock}, 16'd1, "R9 unlock opens lock");
      chk({13'd0, flag_prog_fail, flag_prog_err, flag_abort}, 16'd0, "R9 no failure flags");
      issue(C_PPB_CLR, 2'd0, 16'h0);
      chk({15'd0, ppb_lock}, 16'd0, "R6 clear closes lock in password scheme");

      // R4 R6 reset keeps lock bits, lock closed
      hw_reset();
      chk({15'd0, ppb_lock}, 16'd0, "R6 closed after reset");
      rd(C_LR_READ, 2'd0, 16'hFFFA, "R4 lock bits survive reset");

      // R13 words before start do not count; R10 missing word
      issue(C_UNL_WORD, 2'd1, 16'hABCD);
      issue(C_UNL_START, 2'd0, 16'h0);
      issue(C_UNL_WORD, 2'd0, 16'h1200);
      issue(C_UNL_WORD, 2'd2, 16'h0F0F);
      issue(C_UNL_WORD, 2'd3, 16'h8001);
      issue(C_UNL_EXEC, 2'd0, 16'h0);
      repeat (UNL_CYC + 4) @(negedge clk);
      chk({15'd0, busy}, 16'd1, "R10 busy held after failed unlock");
      chk({15'd0, ppb_lock}, 16'd0, "R13 missing word leaves lock closed");
      chk({13'd0, flag_prog_fail, flag_prog_err, flag_abort}, 16'h0007, "R10 failure flags");
      rd(C_STAT, 2'd0, 16'h00C0, "R11 failed-unlock poll first read");
      rd(C_STAT, 2'd0, 16'h0080, "R11 failed-unlock poll second read");
      rd(C_LR_READ, 2'd0, 16'h0080, "R12 read ignored while busy");

      // R10 mismatch after reset
      hw_reset();
      chk({15'd0, busy}, 16'd0, "R10 reset releases busy");
      chk({13'd0, flag_prog_fail, flag_prog_err, flag_abort}, 16'd0, "R10 reset clears flags");
      unlock_all(16'h1200, 16'hABCC, 16'h0F0F, 16'h8001);
      wait_idle();
      repeat (UNL_CYC + 2) @(negedge clk);
      chk({15'd0, ppb_lock}, 16'd0, "R10 mismatch leaves lock closed");
      chk({13'd0, flag_prog_fail, flag_prog_err, flag_abort}, 16'h0007, "R10 mismatch flags");

      // R1 power-on erases everything
      por_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      rd(C_LR_READ, 2'd0, 16'hFFFF, "R1 power-on erases lock register");
      rd(C_PW_READ, 2'd2, 16'hFFFF, "R1 power-on erases password");
      chk({15'd0, ppb_lock}, 16'd1, "R1 lock open after power-on");

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; fails++;
         $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule